// File: doc/BRIEF.md
# Multichannel Second-Order CIC Decimator

This block low-pass filters and decimates a set of parallel sample streams with a second-order cascaded integrator-comb structure. It produces a single time-multiplexed result stream. All channels arrive together in one packed word, qualified by an input strobe. Each channel feeds its own pair of cascaded integrators, which run at the input rate and use wrap-around arithmetic.

The decimation points are set at run time by strobes rather than by a fixed ratio. A capture strobe freezes the second-integrator value of every channel and loads it into a conveyor belt. The belt then presents the values one channel per cycle on a tap output, which has its own strobe. A separate comb strobe marks the next belt burst for the comb stage. That burst is reduced by a configurable number of noise bits, passed through a second-order difference per channel and scaled by a run-time right shift. It is then emitted with one output strobe per channel, in channel order.

The belt is a two-state machine. In BELT_IDLE, a capture strobe takes the transition "capture" into BELT_SHIFT, which loads the snapshot and latches whether the burst is comb-marked. In BELT_SHIFT, one channel is presented per cycle. After the beat of the highest channel, the transition "last beat" returns the machine to BELT_IDLE.

Top module: `cic2_decim`

## Requirements
- R1: Channel k occupies bits [k*IN_W +: IN_W] of `in_data`, so channel 0 is in the LSBs. On a cycle with `in_stb` high, each channel performs two updates in ACC_W-bit two's-complement with wrap-around. The second integrator is incremented by the old first-integrator value. The first integrator is incremented by the sign-extended input.
- R2: When `smp_stb` is seen in BELT_IDLE, the second-integrator values are captured as they stood before that edge. From the next cycle on, `tap_stb` is high for exactly N_CH consecutive cycles, and `tap_data` carries channel 0, 1, … N_CH-1 in turn.
- R3: A `smp_stb` that arrives during the N_CH cycles of a burst is ignored. It neither lengthens nor restarts the burst.
- R4: A `comb_stb` marks the next burst for the comb stage, or marks the burst captured in the same cycle. A burst that is not marked produces no `out_stb`.
- R5: For each tap word of a marked burst, the comb stage takes c = tap[ACC_W-1:DROP_W]. It forms d = c − 2·c′ + c″ in (ACC_W−DROP_W)-bit wrap-around arithmetic, where c′ and c″ are the values of the same channel from its two previous marked bursts.
- R6: `out_data` is the low OUT_W bits of d arithmetically shifted right by SHIFT_BASE + `shift_sel`. `shift_sel` is sampled in the beat cycle.
- R7: `out_stb` is high the cycle after each tap beat of a marked burst. That gives one pulse per channel, in channel order.
- R8: Synchronous reset clears all integrator, belt and comb history. While reset is held and in the first cycle after it, `tap_stb` and `out_stb` are low and both data outputs are zero.
- R9: Take a constant input x that is a multiple of 2^DROP_W, with exactly M input strobes between marked captures. Once settled, each channel outputs x·M²/2^DROP_W shifted right by SHIFT_BASE + `shift_sel`. This holds even after the integrators have wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_stb | input | 1 | Input sample qualifier |
| in_data | input | N_CH*IN_W | Packed signed samples, channel 0 in LSBs |
| smp_stb | input | 1 | Capture strobe closing an integration interval |
| comb_stb | input | 1 | Marks the next burst for the comb stage |
| shift_sel | input | SHIFT_W | Run-time output right shift |
| tap_stb | output | 1 | Belt beat strobe |
| tap_data | output | ACC_W | Second-integrator value of the current channel |
| out_stb | output | 1 | Filtered result strobe |
| out_data | output | OUT_W | Filtered, scaled result |

## Verification
The bench builds the block with three channels, 8-bit inputs, 24-bit integrators, two noise bits, a 16-bit output, a 2-bit shift and a base shift of 1. Three channels keep bursts short, so a capture strobe can be placed inside a burst. The non-zero base shift checks that the fixed and run-time shifts add. With 24-bit integrators, a few hundred cycles of a large constant input wrap them, which exercises R9 within a short run. The distinct per-channel levels expose any reordering of channels on the belt.

// File: rtl/cic2_pkg.sv
`timescale 1ns/1ps
package cic2_pkg;
    typedef enum logic {
        BELT_IDLE  = 1'b0,
        BELT_SHIFT = 1'b1
    } belt_state_t;
endpackage

// File: rtl/cic2_integ.sv
`timescale 1ns/1ps
module cic2_integ #(
    parameter int IN_W  = 8,
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [IN_W-1:0]         x,
    output logic [ACC_W-1:0]        acc2
);
    localparam int EXT_W = ACC_W - IN_W;

    logic [ACC_W-1:0] stage1;
    logic [ACC_W-1:0] stage2;
    logic [ACC_W-1:0] x_ext;

    assign x_ext = {{EXT_W{x[IN_W-1]}}, x};

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else if (en) begin
            stage1 <= stage1 + x_ext;
            stage2 <= stage2 + stage1;
        end
    end

    assign acc2 = stage2;
endmodule

// File: rtl/cic2_belt.sv
`timescale 1ns/1ps
module cic2_belt
    import cic2_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int W    = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp,
    input  logic              comb,
    input  logic [N_CH*W-1:0] snap,
    output logic              beat,
    output logic [W-1:0]      word,
    output logic              take
);
    localparam int CNT_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CH - 1);

    belt_state_t       st, st_nx;
    logic [N_CH*W-1:0] belt;
    logic [CNT_W-1:0]  cnt;
    logic              armed;
    logic              marked;

    always_comb begin
        st_nx = st;
        unique case (st)
            BELT_IDLE:  if (smp) st_nx = BELT_SHIFT;
            BELT_SHIFT: if (cnt == LAST) st_nx = BELT_IDLE;
            default:    st_nx = BELT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= BELT_IDLE;
        else     st <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            belt   <= '0;
            cnt    <= '0;
            armed  <= 1'b0;
            marked <= 1'b0;
        end else if (st == BELT_IDLE && smp) begin
            belt   <= snap;
            cnt    <= '0;
            marked <= armed | comb;
            armed  <= 1'b0;
        end else begin
            if (comb) armed <= 1'b1;
            if (st == BELT_SHIFT) begin
                belt <= belt >> W;
                cnt  <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        beat = (st == BELT_SHIFT);
        word = belt[W-1:0];
        take = beat & marked;
    end
endmodule

// File: rtl/cic2_comb.sv
`timescale 1ns/1ps
module cic2_comb #(
    parameter int N_CH       = 4,
    parameter int ACC_W      = 24,
    parameter int DROP_W     = 2,
    parameter int OUT_W      = 16,
    parameter int SHIFT_W    = 3,
    parameter int SHIFT_BASE = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [ACC_W-1:0]    word,
    input  logic [SHIFT_W-1:0]  shift_sel,
    output logic                out_stb,
    output logic [OUT_W-1:0]    out_data
);
    localparam int CW = ACC_W - DROP_W;

    logic signed [CW-1:0] hist1 [N_CH];
    logic signed [CW-1:0] hist2 [N_CH];
    logic signed [CW-1:0] cur, diff1, diff2, scaled;
    int unsigned          amount;

    always_comb begin
        cur    = word[ACC_W-1:DROP_W];
        diff1  = cur - hist1[0];
        diff2  = diff1 - hist2[0];
        amount = SHIFT_BASE + int'(shift_sel);
        scaled = diff2 >>> amount;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CH; i++) begin
                hist1[i] <= '0;
                hist2[i] <= '0;
            end
            out_stb  <= 1'b0;
            out_data <= '0;
        end else begin
            out_stb <= take;
            if (take) begin
                for (int i = 0; i < N_CH - 1; i++) begin
                    hist1[i] <= hist1[i+1];
                    hist2[i] <= hist2[i+1];
                end
                hist1[N_CH-1] <= cur;
                hist2[N_CH-1] <= diff1;
                out_data      <= scaled[OUT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cic2_decim.sv
`timescale 1ns/1ps
module cic2_decim #(
    parameter int N_CH       = 4,
    parameter int IN_W       = 8,
    parameter int ACC_W      = 24,
    parameter int DROP_W     = 2,
    parameter int OUT_W      = 16,
    parameter int SHIFT_W    = 3,
    parameter int SHIFT_BASE = 0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_stb,
    input  logic [N_CH*IN_W-1:0]   in_data,
    input  logic                   smp_stb,
    input  logic                   comb_stb,
    input  logic [SHIFT_W-1:0]     shift_sel,
    output logic                   tap_stb,
    output logic [ACC_W-1:0]       tap_data,
    output logic                   out_stb,
    output logic [OUT_W-1:0]       out_data
);
    logic [N_CH*ACC_W-1:0] snap;
    logic                  take;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        cic2_integ #(
            .IN_W  (IN_W),
            .ACC_W (ACC_W)
        ) i_integ (
            .clk  (clk),
            .rst  (rst),
            .en   (in_stb),
            .x    (in_data[ch*IN_W +: IN_W]),
            .acc2 (snap[ch*ACC_W +: ACC_W])
        );
    end

    cic2_belt #(
        .N_CH (N_CH),
        .W    (ACC_W)
    ) i_belt (
        .clk  (clk),
        .rst  (rst),
        .smp  (smp_stb),
        .comb (comb_stb),
        .snap (snap),
        .beat (tap_stb),
        .word (tap_data),
        .take (take)
    );

    cic2_comb #(
        .N_CH       (N_CH),
        .ACC_W      (ACC_W),
        .DROP_W     (DROP_W),
        .OUT_W      (OUT_W),
        .SHIFT_W    (SHIFT_W),
        .SHIFT_BASE (SHIFT_BASE)
    ) i_comb (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .word      (tap_data),
        .shift_sel (shift_sel),
        .out_stb   (out_stb),
        .out_data  (out_data)
    );
endmodule

// File: rtl/cic2_decim_chk.sv
`timescale 1ns/1ps
module cic2_decim_chk #(
    parameter int N_CH = 4
) (
    input logic clk,
    input logic rst,
    input logic smp_stb,
    input logic tap_stb,
    input logic out_stb
);
    localparam int RUN_W = $clog2(N_CH + 2);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)          run <= '0;
        else if (tap_stb) run <= run + 1'b1;
        else              run <= '0;
    end

    AST_BURST_START: assert property (@(posedge clk) disable iff (rst)
        $rose(tap_stb) |-> $past(smp_stb)); // R2

    AST_BURST_LEN: assert property (@(posedge clk) disable iff (rst)
        tap_stb |-> (run < RUN_W'(N_CH))); // R3

    AST_OUT_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        out_stb |-> $past(tap_stb)); // R7

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!tap_stb && !out_stb)); // R8
endmodule

bind cic2_decim cic2_decim_chk #(.N_CH(N_CH)) i_cic2_decim_chk (
    .clk     (clk),
    .rst     (rst),
    .smp_stb (smp_stb),
    .tap_stb (tap_stb),
    .out_stb (out_stb)
);

// File: tb/test_cic2_decim.sv
`timescale 1ns/1ps
module test_cic2_decim;
    localparam int N_CH = 3, IN_W = 8, ACC_W = 24, DROP_W = 2;
    localparam int OUT_W = 16, SHIFT_W = 2, SHIFT_BASE = 1;
    localparam int CW = ACC_W - DROP_W;
    localparam int NSC = 4;
    // stimulus table: base level, ramp step, input strobes per capture, shift
    localparam int TBL [NSC][4] = '{
        '{8, 0, 16, 0}, '{-5, 1, 12, 1}, '{40, -2, 20, 2}, '{3, 3, 9, 3}};

    logic clk = 1'b0, rst = 1'b1;
    logic in_stb = 1'b0, smp_stb = 1'b0, comb_stb = 1'b0;
    logic [SHIFT_W-1:0] shift_sel = '0;
    logic [N_CH*IN_W-1:0] in_data = '0;
    logic tap_stb, out_stb;
    logic [ACC_W-1:0] tap_data;
    logic [OUT_W-1:0] out_data;

    always #10 clk = ~clk;

    cic2_decim #(.N_CH(N_CH), .IN_W(IN_W), .ACC_W(ACC_W), .DROP_W(DROP_W),
        .OUT_W(OUT_W), .SHIFT_W(SHIFT_W), .SHIFT_BASE(SHIFT_BASE)) i_cic2_decim (
        .clk(clk), .rst(rst), .in_stb(in_stb), .in_data(in_data),
        .smp_stb(smp_stb), .comb_stb(comb_stb), .shift_sel(shift_sel),
        .tap_stb(tap_stb), .tap_data(tap_data), .out_stb(out_stb), .out_data(out_data));

    int n_chk = 0, n_bad = 0, tap_cnt = 0, out_cnt = 0, out_idx = 0;
    bit done = 0;
    logic signed [IN_W-1:0]  xin [N_CH];
    logic signed [ACC_W-1:0] m_a1 [N_CH], m_a2 [N_CH];
    logic signed [CW-1:0]    m_h1 [N_CH], m_h2 [N_CH];
    logic [OUT_W-1:0]        last_out [N_CH];
    logic [ACC_W-1:0]        q_tap [$];
    logic [OUT_W-1:0]        q_out [$];
    int  m_busy = 0;
    bit  m_armed = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < N_CH; c++) begin
            m_a1[c] = '0; m_a2[c] = '0; m_h1[c] = '0; m_h2[c] = '0;
        end
        q_tap.delete(); q_out.delete();
        m_busy = 0; m_armed = 0;
    endtask

    // drive one cycle and advance the requirement model to the matching edge
    task automatic step(input bit istb, input bit s, input bit cm, input int shv);
        logic signed [CW-1:0] cc, d1, d2, v;
        bit take;
        @(negedge clk);
        in_stb = istb; smp_stb = s; comb_stb = cm; shift_sel = SHIFT_W'(shv);
        for (int c = 0; c < N_CH; c++) in_data[c*IN_W +: IN_W] = xin[c];
        if (m_busy > 0) begin
            m_busy--;
            if (cm) m_armed = 1;
        end else if (s) begin
            take = m_armed | cm;
            m_armed = 0;
            m_busy = N_CH;
            for (int c = 0; c < N_CH; c++) begin
                q_tap.push_back(m_a2[c]);
                if (take) begin
                    cc = m_a2[c][ACC_W-1:DROP_W];
                    d1 = cc - m_h1[c];
                    d2 = d1 - m_h2[c];
                    m_h1[c] = cc; m_h2[c] = d1;
                    v = d2 >>> (SHIFT_BASE + shv);
                    q_out.push_back(v[OUT_W-1:0]);
                end
            end
        end else if (cm) m_armed = 1;
        if (istb) for (int c = 0; c < N_CH; c++) begin
            m_a2[c] = m_a2[c] + m_a1[c];
            m_a1[c] = m_a1[c] + ACC_W'(xin[c]);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; in_stb = 0; smp_stb = 0; comb_stb = 0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;
        out_idx = 0;
    endtask

    // monitor: compare streams in order against the model queues
    always @(negedge clk) begin
        if (!rst) begin
            if (tap_stb) begin
                tap_cnt++;
                if (q_tap.size() == 0) chk(0, "R2 unexpected tap beat", tap_data, 0);
                else begin
                    automatic logic [ACC_W-1:0] e = q_tap.pop_front();
                    chk(tap_data == e, "R1/R2 tap word", tap_data, e);
                end
            end
            if (out_stb) begin
                out_cnt++;
                last_out[out_idx] = out_data;
                out_idx = (out_idx + 1) % N_CH;
                if (q_out.size() == 0) chk(0, "R4 unexpected output", out_data, 0);
                else begin
                    automatic logic [OUT_W-1:0] e = q_out.pop_front();
                    chk(out_data == e, "R5/R6/R7 output word", out_data, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int t0, o0;
        for (int c = 0; c < N_CH; c++) xin[c] = '0;
        model_clear();
        repeat (3) @(negedge clk);
        // R8: reset state while held and in the first cycle after
        chk(!tap_stb && !out_stb, "R8 strobes in reset", {tap_stb, out_stb}, 0);
        rst = 0;
        @(negedge clk);
        chk(tap_data == 0 && out_data == 0, "R8 data after reset", tap_data, 0);

        // table walk: DC and ramp inputs per channel (R1,R2,R4,R5,R6,R7)
        for (int sc = 0; sc < NSC; sc++) begin
            int n = 0;
            o0 = out_cnt;
            for (int b = 0; b < 6; b++) begin
                for (int j = 0; j < TBL[sc][2]; j++) begin
                    for (int c = 0; c < N_CH; c++)
                        xin[c] = IN_W'(TBL[sc][0] * (c + 1) + TBL[sc][1] * n + c);
                    n++;
                    step(1, j == TBL[sc][2] - 1, (j == 1) && (b != 3), TBL[sc][3]);
                end
            end
            repeat (N_CH + 3) step(0, 0, 0, TBL[sc][3]);
            chk(out_cnt - o0 == 5 * N_CH, "R4 bursts marked per scenario", out_cnt - o0, 5 * N_CH);
        end

        // R3: capture strobes inside a burst are ignored
        t0 = tap_cnt; o0 = out_cnt;
        step(0, 1, 1, 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        repeat (N_CH + 3) step(0, 0, 0, 0);
        chk(tap_cnt - t0 == N_CH, "R3 beats per burst", tap_cnt - t0, N_CH);
        chk(out_cnt - o0 == N_CH, "R4 same-cycle mark", out_cnt - o0, N_CH);

        // R4: an unmarked burst yields no output
        t0 = tap_cnt; o0 = out_cnt;
        step(0, 1, 0, 0);
        repeat (N_CH + 3) step(0, 0, 0, 0);
        chk(tap_cnt - t0 == N_CH, "R4 unmarked burst beats", tap_cnt - t0, N_CH);
        chk(out_cnt - o0 == 0, "R4 unmarked burst outputs", out_cnt - o0, 0);

        // R9 / R8: after reset, steady DC through integrator wrap
        do_reset();
        chk(!tap_stb && !out_stb && out_data == 0, "R8 cleared after mid-run reset", out_data, 0);
        xin[0] = 8; xin[1] = 120; xin[2] = -64;
        for (int b = 0; b < 40; b++)
            for (int j = 0; j < 16; j++) step(1, j == 15, j == 2, 0);
        repeat (N_CH + 3) step(0, 0, 0, 0);
        chk(last_out[0] == OUT_W'(256),   "R9 ch0 steady level", longint'(signed'(last_out[0])), 256);
        chk(last_out[1] == OUT_W'(3840),  "R9 ch1 steady level", longint'(signed'(last_out[1])), 3840);
        chk(last_out[2] == OUT_W'(-2048), "R9 ch2 steady level", longint'(signed'(last_out[2])), -2048);

        chk(q_tap.size() == 0 && q_out.size() == 0, "R2/R7 all expected words seen",
            q_tap.size() + q_out.size(), 0);
        finish_run();
    end
endmodule